// File: doc/BRIEF.md
# Interrupt Entry Bus Signature Detector

This block follows a processor bus one cycle at a time and decides whether the instruction that was expected to start has been replaced by an interrupt or reset entry sequence. A separate decoder supplies a strobe for every bus cycle, the data byte, the read/write flag and a marker on the cycle it expects to be an opcode fetch. That marker cycle is cycle 0. The detector looks for stack pushes that land exactly in cycles 2, 3 and 4. When it finds them, it reports an entry and then takes the next two reads as the low and high bytes of the handler address.

A store that is held in wait states can also show several writes in a row. It writes the same byte on every extended cycle, and the detector uses this to reject it. Genuine stacking writes push three different values. The entry is only accepted if the decoder has opened the interrupt window for that instruction, because some instructions delay the response. A pattern that looks like an entry but is refused raises a mismatch pulse, so the decoder can resynchronise. A missed reset on a processor that also stacks three bytes is seen as an entry, and it still yields the correct start address.

Top module: `irq_entry_detect`

## Requirements
- R1: After reset, `irq_entry`, `vec_valid` and `sync_err` are 0 and `vec_pc` is 0.
- R2: The marker cycle is cycle 0, and only strobed cycles count. If cycles 2, 3 and 4 are all writes (`bus_rnw`=0), their data are not all the same byte, and `irq_window` was 1 on the marker cycle, then `irq_entry` is 1 for exactly one clock after the cycle-4 strobe edge.
- R3: If cycles 2, 3 and 4 are writes of one identical byte, no entry is reported and `sync_err` pulses for one clock after the cycle-4 strobe.
- R4: Writes that do not cover all of cycles 2, 3 and 4 produce neither `irq_entry` nor `sync_err`. This covers a single store write in cycle 3 and writes in cycles 3, 4 and 5.
- R5: If `irq_window` was 0 on the marker cycle, three distinct writes in cycles 2 to 4 produce `sync_err` and no `irq_entry`.
- R6: After an entry, the read in cycle 5 gives the low byte and the read in cycle 6 gives the high byte. After the cycle-6 strobe, `vec_valid` pulses for one clock and `vec_pc` = {high, low}. `vec_pc` then holds until the next such pulse.
- R7: A write in cycle 5 or cycle 6 after an entry pulses `sync_err`, produces no `vec_valid`, and leaves `vec_pc` unchanged.
- R8: A marker arriving part-way through a sequence discards it, and counting restarts from the new marker.
- R9: Clocks with `cyc_stb`=0 neither advance the cycle count nor sample the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | One bus cycle is presented on this clock |
| instr_start | input | 1 | Marks the current strobed cycle as the predicted opcode fetch |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_data | input | DW (8) | Bus data byte |
| irq_window | input | 1 | Interrupt entry allowed for this instruction (sampled at the marker) |
| irq_entry | output | 1 | One-clock pulse: entry signature recognised |
| vec_valid | output | 1 | One-clock pulse: new program counter captured |
| vec_pc | output | 2*DW (16) | Captured handler address |
| sync_err | output | 1 | One-clock pulse: signature-like pattern rejected or vector fetch broken |

## Verification
The hardest case to reach from the ports is a run of writes that covers cycles 2 to 4 but is still not an entry. This happens either because the bytes repeat or because the window was closed. The only thing that separates these from a genuine entry is which pulse appears on the cycle-4 edge. The directed stimulus replays the same three-write shape with distinct bytes, then with one repeated byte, then with the window closed. It also replays a version shifted by one cycle and one that is cut off by a fresh marker. A separate run inserts idle clocks between strobes, so that counting by strobe rather than by clock is exercised.

// File: rtl/irqsig_pkg.sv
package irqsig_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_WATCH = 2'd1,
      PH_LO    = 2'd2,
      PH_HI    = 2'd3
   } phase_t;
endpackage

// File: rtl/irqsig_slot_hist.sv
module irqsig_slot_hist #(
   parameter int DW            = 8,
   parameter int FIRST_WR      = 2,
   parameter int NUM_WR        = 3,
   parameter int CW            = 4,
   parameter bit REJECT_REPEAT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb,
   input  logic          clr,
   input  logic [CW-1:0] cyc_idx,
   input  logic          rnw,
   input  logic [DW-1:0] data,
   output logic          all_wr,
   output logic          all_same
);
   localparam int HELD = NUM_WR - 1;

   logic [HELD-1:0] wr_vec;
   logic [HELD-1:0] eq_vec;

   for (genvar i = 0; i < HELD; i++) begin : g_slot
      localparam logic [CW-1:0] SLOT = CW'(FIRST_WR + i);
      logic          wr_r;
      logic [DW-1:0] d_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_r <= 1'b0;
            d_r  <= '0;
         end else if (stb) begin
            if (clr) begin
               wr_r <= 1'b0;
            end else if (cyc_idx == SLOT) begin
               wr_r <= ~rnw;
               d_r  <= data;
            end
         end
      end
      assign wr_vec[i] = wr_r;
      assign eq_vec[i] = (d_r == data);
   end

   assign all_wr = (&wr_vec) & ~rnw;

   if (REJECT_REPEAT) begin : g_rej
      assign all_same = &eq_vec;
   end else begin : g_norej
      assign all_same = 1'b0;
   end
endmodule

// File: rtl/irqsig_vec_asm.sv
module irqsig_vec_asm #(
   parameter int DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lo_we,
   input  logic            hi_we,
   input  logic [DW-1:0]   data,
   output logic [2*DW-1:0] pc
);
   logic [DW-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         pc   <= '0;
      end else begin
         if (lo_we) lo_q <= data;
         if (hi_we) pc   <= {data, lo_q};
      end
   end
endmodule

// File: rtl/irq_entry_detect.sv
module irq_entry_detect #(
   parameter int DW            = 8,
   parameter int FIRST_WR      = 2,
   parameter int NUM_WR        = 3,
   parameter bit REJECT_REPEAT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cyc_stb,
   input  logic            instr_start,
   input  logic            bus_rnw,
   input  logic [DW-1:0]   bus_data,
   input  logic            irq_window,
   output logic            irq_entry,
   output logic            vec_valid,
   output logic [2*DW-1:0] vec_pc,
   output logic            sync_err
);
   import irqsig_pkg::*;

   localparam int LAST = FIRST_WR + NUM_WR - 1;
   localparam int SAT  = LAST + 1;
   localparam int CW   = $clog2(LAST + 3) + 1;
   localparam logic [CW-1:0] LAST_C = CW'(LAST);
   localparam logic [CW-1:0] SAT_C  = CW'(SAT);

   if (DW < 1) begin : g_bad_dw
      $error("DW must be at least 1");
   end
   if (NUM_WR < 2) begin : g_bad_nw
      $error("NUM_WR must be at least 2");
   end
   if (FIRST_WR < 1) begin : g_bad_fw
      $error("FIRST_WR must be at least 1");
   end

   phase_t        phase_q;
   logic [CW-1:0] cyc_q;
   logic          win_q;
   logic          all_wr, all_same;
   logic          fire, at_last, sig_ok, sig_bad, lo_we, hi_we, vec_fault;

   irqsig_slot_hist #(
      .DW(DW), .FIRST_WR(FIRST_WR), .NUM_WR(NUM_WR), .CW(CW),
      .REJECT_REPEAT(REJECT_REPEAT)
   ) i_hist (
      .clk(clk), .rst_n(rst_n), .stb(cyc_stb), .clr(instr_start),
      .cyc_idx(cyc_q), .rnw(bus_rnw), .data(bus_data),
      .all_wr(all_wr), .all_same(all_same)
   );

   irqsig_vec_asm #(.DW(DW)) i_vec (
      .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .hi_we(hi_we),
      .data(bus_data), .pc(vec_pc)
   );

   always_comb begin
      fire      = cyc_stb & ~instr_start;
      at_last   = (phase_q == PH_WATCH) && (cyc_q == LAST_C);
      sig_ok    = at_last & all_wr & win_q & ~all_same;
      sig_bad   = at_last & all_wr & ~(win_q & ~all_same);
      lo_we     = fire && (phase_q == PH_LO) && bus_rnw;
      hi_we     = fire && (phase_q == PH_HI) && bus_rnw;
      vec_fault = fire && ((phase_q == PH_LO) || (phase_q == PH_HI)) && !bus_rnw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
      end else if (cyc_stb) begin
         if (instr_start)       cyc_q <= CW'(1);
         else if (cyc_q < SAT_C) cyc_q <= cyc_q + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         win_q   <= 1'b0;
      end else if (cyc_stb) begin
         if (instr_start) begin
            phase_q <= PH_WATCH;
            win_q   <= irq_window;
         end else begin
            unique case (phase_q)
               PH_WATCH: if (cyc_q == LAST_C) phase_q <= sig_ok ? PH_LO : PH_IDLE;
               PH_LO:    phase_q <= bus_rnw ? PH_HI : PH_IDLE;
               PH_HI:    phase_q <= PH_IDLE;
               default:  phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_entry <= 1'b0;
         vec_valid <= 1'b0;
         sync_err  <= 1'b0;
      end else begin
         irq_entry <= fire & sig_ok;
         vec_valid <= hi_we;
         sync_err  <= fire & (sig_bad | vec_fault);
      end
   end
endmodule

// File: rtl/irqsig_chk.sv
module irqsig_chk #(
   parameter int DW = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cyc_stb,
   input logic            bus_rnw,
   input logic [DW-1:0]   bus_data,
   input logic            irq_entry,
   input logic            vec_valid,
   input logic [2*DW-1:0] vec_pc,
   input logic            sync_err
);
   AST_ENTRY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_entry |-> $past(cyc_stb && !bus_rnw)); // R2
   AST_ENTRY_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_entry && sync_err)); // R3
   AST_ENTRY_NEXT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      irq_entry |=> !vec_valid); // R6
   AST_VALID_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(cyc_stb && bus_rnw)); // R6
   AST_VALID_HI_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec_pc[2*DW-1:DW] == $past(bus_data))); // R6
   AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> $stable(vec_pc)); // R7
   AST_PULSE_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_entry || sync_err || vec_valid) |-> $past(cyc_stb)); // R9
endmodule

bind irq_entry_detect irqsig_chk #(.DW(DW)) i_chk (
   .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .bus_rnw(bus_rnw),
   .bus_data(bus_data), .irq_entry(irq_entry), .vec_valid(vec_valid),
   .vec_pc(vec_pc), .sync_err(sync_err)
);

// File: tb/test_irq_entry_detect.sv
`timescale 1ns/1ps
module test_irq_entry_detect;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_stb = 1'b0;
   logic        instr_start = 1'b0;
   logic        bus_rnw = 1'b1;
   logic [7:0]  bus_data = 8'h00;
   logic        irq_window = 1'b1;
   logic        irq_entry, vec_valid, sync_err;
   logic [15:0] vec_pc;

   int n_run = 0, n_fail = 0;
   int seen_ent = 0, seen_mis = 0, seen_val = 0;
   int gap = 0;

   always #2 clk = ~clk;

   irq_entry_detect i_irq_entry_detect (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .instr_start(instr_start),
      .bus_rnw(bus_rnw), .bus_data(bus_data), .irq_window(irq_window),
      .irq_entry(irq_entry), .vec_valid(vec_valid), .vec_pc(vec_pc),
      .sync_err(sync_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input logic st, input logic rnw, input logic [7:0] d);
      @(negedge clk);
      cyc_stb = 1'b1; instr_start = st; bus_rnw = rnw; bus_data = d;
      @(posedge clk); #1;
      cyc_stb = 1'b0; instr_start = 1'b0; bus_rnw = 1'b1;
      if (irq_entry) seen_ent++;
      if (sync_err)  seen_mis++;
      if (vec_valid) seen_val++;
      for (int k = 0; k < gap; k++) @(posedge clk);
   endtask

   task automatic clr_seen();
      seen_ent = 0; seen_mis = 0; seen_val = 0;
   endtask

   task automatic t_reset();
      check("R1 entry", irq_entry, 0);
      check("R1 valid", vec_valid, 0);
      check("R1 err", sync_err, 0);
      check("R1 pc", vec_pc, 16'h0000);
   endtask

   task automatic t_genuine(input logic [7:0] lo, input logic [7:0] hi, input string tag);
      clr_seen();
      irq_window = 1'b1;
      step(1, 1, 8'hA9);
      step(0, 1, 8'h40);
      step(0, 0, 8'hE3);
      step(0, 0, 8'h6C);
      check({tag, " R2 no early entry"}, seen_ent, 0);
      step(0, 0, 8'h24);
      check({tag, " R2 entry at cycle 4"}, seen_ent, 1);
      check({tag, " R2 no err"}, seen_mis, 0);
      step(0, 1, lo);
      check({tag, " R6 no valid after low"}, seen_val, 0);
      step(0, 1, hi);
      check({tag, " R6 valid"}, seen_val, 1);
      check({tag, " R6 pc"}, vec_pc, {hi, lo});
      step(1, 1, 8'hD8);
      check({tag, " R6 pc held"}, vec_pc, {hi, lo});
      check({tag, " R2 single entry"}, seen_ent, 1);
   endtask

   task automatic t_stretched();
      clr_seen();
      step(1, 1, 8'h85);
      step(0, 1, 8'h10);
      step(0, 0, 8'h53);
      step(0, 0, 8'h53);
      step(0, 0, 8'h53);
      check("R3 err pulse", seen_mis, 1);
      step(0, 1, 8'h11);
      step(0, 1, 8'h22);
      check("R3 no entry", seen_ent, 0);
      check("R3 no valid", seen_val, 0);
      check("R3 pc kept", vec_pc, 16'hE364);
   endtask

   task automatic t_normal_store();
      clr_seen();
      step(1, 1, 8'h8D);
      step(0, 1, 8'h00);
      step(0, 1, 8'h0D);
      step(0, 0, 8'h40);
      step(1, 1, 8'h78);
      step(0, 1, 8'h8D);
      step(0, 1, 8'h30);
      step(0, 0, 8'h0F);
      step(0, 0, 8'h0F);
      step(0, 0, 8'h0F);
      step(0, 1, 8'h60);
      step(0, 1, 8'h01);
      check("R4 no entry", seen_ent, 0);
      check("R4 no err", seen_mis, 0);
      check("R4 no valid", seen_val, 0);
   endtask

   task automatic t_window_closed();
      clr_seen();
      irq_window = 1'b0;
      step(1, 1, 8'hF0);
      irq_window = 1'b1;
      step(0, 1, 8'h05);
      step(0, 0, 8'h12);
      step(0, 0, 8'h34);
      step(0, 0, 8'h56);
      step(0, 1, 8'h78);
      step(0, 1, 8'h9A);
      check("R5 no entry", seen_ent, 0);
      check("R5 err", seen_mis, 1);
      check("R5 no valid", seen_val, 0);
   endtask

   task automatic t_vec_write();
      clr_seen();
      step(1, 1, 8'hEA);
      step(0, 1, 8'hEA);
      step(0, 0, 8'h81);
      step(0, 0, 8'h82);
      step(0, 0, 8'h83);
      check("R7 entry first", seen_ent, 1);
      step(0, 0, 8'h99);
      check("R7 err on vector write", seen_mis, 1);
      step(0, 1, 8'h55);
      check("R7 no valid", seen_val, 0);
      check("R7 pc unchanged", vec_pc, 16'hE364);
   endtask

   task automatic t_abort();
      clr_seen();
      step(1, 1, 8'h20);
      step(0, 1, 8'h01);
      step(0, 0, 8'h91);
      step(0, 0, 8'h92);
      step(1, 1, 8'hA2);
      step(0, 1, 8'h02);
      step(0, 1, 8'h03);
      check("R8 no entry after restart", seen_ent, 0);
      step(1, 1, 8'h20);
      step(0, 1, 8'h01);
      step(0, 0, 8'h91);
      step(0, 0, 8'h92);
      step(1, 1, 8'hA2);
      step(0, 1, 8'h02);
      step(0, 0, 8'hA1);
      step(0, 0, 8'hA2);
      step(0, 0, 8'hA3);
      check("R8 entry from new marker", seen_ent, 1);
      step(0, 1, 8'h00);
      step(0, 1, 8'h80);
      check("R8 pc", vec_pc, 16'h8000);
   endtask

   task automatic t_gaps();
      gap = 3;
      t_genuine(8'h20, 8'h80, "R9 gaps");
      check("R9 entry pulse gone", irq_entry, 0);
      check("R9 valid pulse gone", vec_valid, 0);
      gap = 0;
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_genuine(8'h64, 8'hE3, "R2/R6 base");
      t_stretched();
      t_normal_store();
      t_window_closed();
      t_vec_write();
      t_abort();
      t_gaps();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule